// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block works out how many master clock (MCLK) cycles make up one period of the audio word clock (LRCLK) when the audio interface is a clock slave. It maps that count onto one of six supported oversampling ratios: 128, 192, 256, 384, 512 or 768 times the sample rate. A downstream filter engine uses the result to pick its clock arrangement. The detector reports a 3-bit ratio code, a flag that says whether a classification has settled, and the internal oversampling selection that follows from the ratio.

LRCLK is asynchronous to MCLK. It passes through a two-flop synchroniser, and rising edges are detected in the MCLK domain. A saturating counter measures the distance between rising edges. A tolerance window accepts periods that sit close to a nominal ratio. Any count that falls outside every window, a stopped word clock included, falls back to the 768 setting. A measurement only reaches the outputs when the next measurement classifies to the same ratio. A single disturbed period therefore does not change the result.

Top module: `mclk_ratio_det`

## Requirements
- R1: `ratio_o` encodes the ratio as 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 and never takes a value above 5.
- R2: A measured period lies within a ratio's window when it differs from that ratio's nominal count by no more than TOL (default 32). When a count falls in two windows (for example 160 or 224), the lower ratio is chosen.
- R3: A measured period outside every window classifies as code 5 (768).
- R4: `osr_64_o` is 1 when the reported code is 0 or 1 (64x internal oversampling) and 0 for every other code (128x).
- R5: A measurement equals the number of MCLK cycles between successive synchronised LRCLK rising edges. The first rising edge after reset only starts a measurement.
- R6: `ratio_o` and `osr_64_o` change only when two consecutive measurements classify to the same ratio. A single measurement that differs from the one before it leaves the outputs unchanged.
- R7: During and after reset, `valid_o` is 0, `ratio_o` is 5 and `osr_64_o` is 0. `valid_o` becomes 1 at the first update and stays 1 until the next reset.
- R8: The period counter saturates at 2^CNT_W-1 (2047 by default). Reaching that value closes a measurement of that value and restarts counting, so a stopped LRCLK drives the outputs to code 5 after two such windows.
- R9: An update reaches the outputs on the fourth MCLK rising edge after the LRCLK rising edge that completes the second agreeing period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (MCLK) |
| rst | input | 1 | Synchronous active-high reset |
| lrclk_i | input | 1 | Word clock, asynchronous to clk |
| ratio_o | output | 3 | Detected ratio code (R1) |
| valid_o | output | 1 | A classification has settled since reset |
| osr_64_o | output | 1 | 1 selects 64x internal oversampling, 0 selects 128x |

## Verification
Each result appears a fixed number of MCLK edges after the LRCLK rising edge that closes a period. The synchroniser takes two edges, the measurement register one more, and the output register a fourth. The bench drives LRCLK on falling edges and samples on falling edges. Table vectors are sampled a whole low phase after the last closing edge, well past that latency. The latency check samples after the third edge, where the old code must still be present, and again after the fourth, where the new code must appear. The stopped-clock case is sampled both between the two saturation windows and after the second one.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

    localparam int NUM_RATIOS = 6;
    localparam int RATIO_W    = 3;

    typedef enum logic [RATIO_W-1:0] {
        RATIO_128 = 3'd0,
        RATIO_192 = 3'd1,
        RATIO_256 = 3'd2,
        RATIO_384 = 3'd3,
        RATIO_512 = 3'd4,
        RATIO_768 = 3'd5
    } ratio_e;

    localparam ratio_e RATIO_DEFAULT = RATIO_768;

    typedef struct packed {
        logic   hit;
        ratio_e ratio;
    } class_t;

    function automatic int ratio_nominal(int idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            default: return 768;
        endcase
    endfunction

    function automatic logic ratio_is_low_osr(ratio_e r);
        return (r == RATIO_128) || (r == RATIO_192);
    endfunction

endpackage

// File: rtl/lrclk_edge_sync.sv
module lrclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lrclk_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], lrclk_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R5

endmodule

// File: rtl/mclk_period_counter.sv
module mclk_period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            primed_q     <= 1'b0;
            meas_valid_o <= 1'b0;
            meas_cnt_o   <= '0;
        end else begin
            meas_valid_o <= 1'b0;
            if (rise_i) begin
                if (primed_q) begin
                    meas_valid_o <= 1'b1;
                    meas_cnt_o   <= cnt_q;
                end
                cnt_q    <= CNT_ONE;
                primed_q <= 1'b1;
            end else if (primed_q) begin
                if (cnt_q == CNT_MAX) begin
                    meas_valid_o <= 1'b1;
                    meas_cnt_o   <= CNT_MAX;
                    cnt_q        <= CNT_ONE;
                end else begin
                    cnt_q <= cnt_q + CNT_ONE;
                end
            end
        end
    end

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        primed_q |-> (cnt_q != '0)); // R8

    AST_MEAS_NONZERO: assert property (@(posedge clk) disable iff (rst)
        meas_valid_o |-> (meas_cnt_o != '0)); // R5

endmodule

// File: rtl/mclk_ratio_classifier.sv
module mclk_ratio_classifier
    import mclk_ratio_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] meas_cnt_i,
    output class_t           cls_o
);
    logic [NUM_RATIOS-1:0] win;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int NOM = ratio_nominal(g);
        assign win[g] = (int'(meas_cnt_i) >= NOM - TOL) &&
                        (int'(meas_cnt_i) <= NOM + TOL);
    end

    always_comb begin
        cls_o.hit   = 1'b0;
        cls_o.ratio = RATIO_DEFAULT;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (win[i]) begin
                cls_o.hit   = 1'b1;
                cls_o.ratio = ratio_e'(RATIO_W'(i));
            end
        end
    end

    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        cls_o.hit |->
            ((int'(meas_cnt_i) - ratio_nominal(int'(cls_o.ratio)) <= TOL) &&
             (ratio_nominal(int'(cls_o.ratio)) - int'(meas_cnt_i) <= TOL))); // R2

endmodule

// File: rtl/mclk_ratio_qualifier.sv
module mclk_ratio_qualifier
    import mclk_ratio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   evt_i,
    input  ratio_e cls_i,
    output ratio_e ratio_o,
    output logic   osr_low_o,
    output logic   valid_o
);
    ratio_e prev_q;
    logic   have_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= RATIO_DEFAULT;
            have_prev_q <= 1'b0;
            ratio_o     <= RATIO_DEFAULT;
            osr_low_o   <= 1'b0;
            valid_o     <= 1'b0;
        end else if (evt_i) begin
            prev_q      <= cls_i;
            have_prev_q <= 1'b1;
            if (have_prev_q && (cls_i == prev_q)) begin
                ratio_o   <= cls_i;
                osr_low_o <= ratio_is_low_osr(cls_i);
                valid_o   <= 1'b1;
            end
        end
    end

    AST_UPDATE_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst)
        !$stable(ratio_o) |-> $past(evt_i && have_prev_q && (cls_i == prev_q))); // R6

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o); // R7

    AST_OSR_TRACKS: assert property (@(posedge clk) disable iff (rst)
        osr_low_o == ((ratio_o == RATIO_128) || (ratio_o == RATIO_192))); // R4

endmodule

// File: rtl/mclk_ratio_det.sv
module mclk_ratio_det
    import mclk_ratio_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 11,
    parameter int TOL         = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               lrclk_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               valid_o,
    output logic               osr_64_o
);
    logic             rise;
    logic             meas_valid;
    logic [CNT_W-1:0] meas_cnt;
    class_t           cls;
    ratio_e           ratio_q;

    lrclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .lrclk_i (lrclk_i),
        .rise_o  (rise)
    );

    mclk_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .rise_i       (rise),
        .meas_valid_o (meas_valid),
        .meas_cnt_o   (meas_cnt)
    );

    mclk_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .clk        (clk),
        .rst        (rst),
        .meas_cnt_i (meas_cnt),
        .cls_o      (cls)
    );

    mclk_ratio_qualifier u_qual (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (meas_valid),
        .cls_i     (cls.ratio),
        .ratio_o   (ratio_q),
        .osr_low_o (osr_64_o),
        .valid_o   (valid_o)
    );

    assign ratio_o = ratio_q;

    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        ratio_o <= 3'd5); // R1

endmodule

// File: tb/mclk_ratio_det_tb_top.sv
module mclk_ratio_det_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lrclk = 1'b0;
    logic [2:0] ratio;
    logic       valid;
    logic       osr64;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    mclk_ratio_det dut_i (
        .clk      (clk),
        .rst      (rst),
        .lrclk_i  (lrclk),
        .ratio_o  (ratio),
        .valid_o  (valid),
        .osr_64_o (osr64)
    );

    localparam int NV = 14;
    localparam int V_PER[NV]  = '{256, 128, 192, 384, 512, 768, 288, 224, 320, 160, 96, 95, 384, 416};
    localparam int V_JIT[NV]  = '{  0,   0,   0,   0,   0,   0,   0,   0,   0,   0,  0,  0,  20,   0};
    localparam int V_CODE[NV] = '{  2,   0,   1,   3,   4,   5,   2,   1,   5,   0,  0,  5,   3,   3};

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_period(int len);
        lrclk = 1'b1;
        repeat (len / 2) @(negedge clk);
        lrclk = 1'b0;
        repeat (len - len / 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7 valid in reset", int'(valid), 0);
        check("R7 ratio in reset", int'(ratio), 5);
        check("R7 osr in reset", int'(osr64), 0);
        rst = 1'b0;
        @(negedge clk);

        // R5/R6: first edge primes, one measurement alone does not update
        drive_period(256);
        drive_period(256);
        repeat (5) @(negedge clk);
        check("R5 no update before pair", int'(valid), 0);
        check("R6 ratio held before pair", int'(ratio), 5);

        // R1 R2 R3 R4: table of periods
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 4; k++) begin
                drive_period(V_PER[v] + ((k % 2 == 0) ? V_JIT[v] : -V_JIT[v]));
            end
            check($sformatf("R2/R3 code for period %0d", V_PER[v]), int'(ratio), V_CODE[v]);
            check($sformatf("R4 osr for period %0d", V_PER[v]), int'(osr64), (V_CODE[v] < 2) ? 1 : 0);
            check("R7 valid after update", int'(valid), 1);
        end

        // R6: a single differing period is ignored
        for (int k = 0; k < 3; k++) drive_period(256);
        drive_period(512);
        drive_period(256);
        check("R6 single 512 ignored", int'(ratio), 2);
        drive_period(512);
        check("R6 still 256 after lone 512", int'(ratio), 2);

        // R9: latency of the update
        drive_period(512);
        lrclk = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 old code after third edge", int'(ratio), 2);
        @(posedge clk);
        @(negedge clk);
        check("R9 new code after fourth edge", int'(ratio), 4);
        repeat (254) @(negedge clk);

        // R8: stopped word clock
        lrclk = 1'b0;
        repeat (2100) @(negedge clk);
        check("R8 one saturation window keeps code", int'(ratio), 4);
        repeat (2200) @(negedge clk);
        check("R8 stopped clock falls back", int'(ratio), 5);
        check("R8 osr after fallback", int'(osr64), 0);
        check("R8 valid after fallback", int'(valid), 1);

        // R7: reset in mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 valid cleared by reset", int'(valid), 0);
        check("R7 ratio restored by reset", int'(ratio), 5);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule